// File: doc/BRIEF.md
# I2C Slave Quad Setting Register Controller

This block is a serial-bus slave that owns four 8-bit volatile setting registers. Each register drives one wiper-position output bus. The block runs on a system clock that is faster than the bus. It samples SCL and SDA, which are assumed to be synchronised to that clock already. Its only drive onto the bus is an open-drain pull-down enable for SDA.

A host reaches the block in one of two ways:

- **Write.** START, then an identification byte, then a register address, then one data byte, then STOP.
- **Read.** The same identification and address bytes, then a repeated START, then the identification byte again with the read flag set. The slave then streams register contents for as long as the host acknowledges each byte. The read pointer wraps through the four registers.

The identification byte carries a fixed five-bit prefix and two bits that must match a pair of strap inputs. Several of these controllers can therefore share one bus.

Top module: `i2c_quad_setting_ctrl`

## Requirements
- R1: While reset is held and after it is released, all four register outputs read 80h and the SDA enable is low (bus released).
- R2: The identification byte is valid only when bits [7:3] are 01010 and bits [2:1] equal strap_i[1:0]. Bit 0 selects read (1) or write (0). A mismatching identification byte gets no ACK, and the block ignores the rest of the transfer until the next START.
- R3: An address byte of 00h to 03h is acknowledged and selects register 0 to 3, so that exactly one register can change per write. An address byte of 04h to FFh is not acknowledged, leaves the pointer unchanged and causes the following data byte to be ignored.
- R4: A write consists of START, identification with bit 0 = 0, address, data and STOP. The block pulls SDA low in the ninth clock of each of the three bytes. The addressed register takes the data byte while SCL is high on the eighth data bit, so the new value is visible during that byte's ACK clock. The other registers keep their values.
- R5: After the address phase, a repeated START and an identification byte with bit 0 = 1 are acknowledged. The block then shifts out the register selected by the pointer, MSB first, on successive SCL low phases.
- R6: During a read, the pointer advances by one after each transmitted byte and wraps from register 3 to register 0. Transmission continues for as long as the host acknowledges.
- R7: When the host does not acknowledge a read byte, the block keeps SDA released. It drives nothing more until the next START.
- R8: Bus traffic before the first START never causes the block to drive SDA and never changes a register.
- R9: A STOP leaves SDA released from the next cycle on. Bytes that follow without a new START are ignored.
- R10: The SDA enable changes only while SCL is low. It asserts only after a detected SCL falling edge.
- R11: A second data byte within one write transfer is not acknowledged and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| strap_i | input | 2 | Strap levels compared with identification bits [2:1] |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| wiper_o | output | NUM_REGS*8 | Register values; register i is at bits [8i+7:8i] |

## Verification
The bench targets four areas:

- **Pointer wrap.** Reads start at register 3 and run past the last register. A design that fails to wrap would stream a stale or out-of-range value after 03h.
- **Rejected addresses.** The bench issues a rejected address and then does a repeated-START read. A design that loads the pointer before it checks the address would return the wrong register.
- **Silence after a host NACK or a STOP.** The bench clocks further bytes without a START. A design that keeps its state would acknowledge them or overwrite a register.
- **Rejections by the strap and prefix checks, and a surplus data byte.** These transfers must produce no ACK and must leave every register unchanged.

// File: rtl/i2c_quad_pkg.sv
package i2c_quad_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACKPEND,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_TXLOAD,
        ST_WAIT
    } ctl_state_e;

    typedef enum logic [1:0] {
        PH_ID,
        PH_ADDR,
        PH_DATA
    } byte_phase_e;

    typedef enum logic [1:0] {
        NX_RX,
        NX_TX,
        NX_WAIT
    } after_ack_e;

endpackage

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        scl_rise  = scl_i & ~scl_q;
        scl_fall  = ~scl_i & scl_q;
        start_det = scl_i & scl_q & sda_q & ~sda_i;
        stop_det  = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/setting_bank.sv
module setting_bank #(
    parameter int NUM_REGS  = 4,
    parameter int PTR_W     = 2,
    parameter logic [i2c_quad_pkg::BYTE_W-1:0] RESET_VAL = 8'h80
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [PTR_W-1:0]                      wr_idx,
    input  logic [i2c_quad_pkg::BYTE_W-1:0]       wr_data,
    input  logic [PTR_W-1:0]                      rd_idx,
    output logic [i2c_quad_pkg::BYTE_W-1:0]       rd_data,
    output logic [NUM_REGS*i2c_quad_pkg::BYTE_W-1:0] vals_o
);
    import i2c_quad_pkg::*;

    logic [BYTE_W-1:0] val_q [NUM_REGS];

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        logic [BYTE_W-1:0] val_d;
        always_comb begin
            val_d = val_q[gi];
            if (wr_en && (int'(wr_idx) == gi)) val_d = wr_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q[gi] <= RESET_VAL;
            else        val_q[gi] <= val_d;
        end
        assign vals_o[gi*BYTE_W +: BYTE_W] = val_q[gi];
    end

    always_comb begin
        rd_data = val_q[0];
        for (int i = 0; i < NUM_REGS; i++) begin
            if (int'(rd_idx) == i) rd_data = val_q[i];
        end
    end
endmodule

// File: rtl/i2c_quad_setting_ctrl.sv
module i2c_quad_setting_ctrl #(
    parameter int NUM_REGS = 4,
    parameter logic [i2c_quad_pkg::BYTE_W-1:0] RESET_VAL = 8'h80,
    parameter logic [4:0] ID_PREFIX = 5'b01010
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     scl_i,
    input  logic                                     sda_i,
    input  logic [1:0]                               strap_i,
    output logic                                     sda_oe_o,
    output logic [NUM_REGS*i2c_quad_pkg::BYTE_W-1:0] wiper_o
);
    import i2c_quad_pkg::*;

    localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_REGS - 1);

    typedef struct packed {
        ctl_state_e        st;
        byte_phase_e       ph;
        after_ack_e        nx;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sr;
        logic [PTR_W-1:0]  ptr;
        logic              oe;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] rd_data;
    logic              id_ok, addr_ok;

    i2c_line_monitor u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    setting_bank #(
        .NUM_REGS  (NUM_REGS),
        .PTR_W     (PTR_W),
        .RESET_VAL (RESET_VAL)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (ctl_q.ptr),
        .wr_data (rx_byte),
        .rd_idx  (ctl_q.ptr),
        .rd_data (rd_data),
        .vals_o  (wiper_o)
    );

    assign rx_byte = {ctl_q.sr[BYTE_W-2:0], sda_i};
    assign id_ok   = (rx_byte[7:3] == ID_PREFIX) && (rx_byte[2:1] == strap_i);
    assign addr_ok = int'(rx_byte) < NUM_REGS;

    always_comb begin
        ctl_d = ctl_q;
        wr_en = 1'b0;
        if (start_det) begin
            ctl_d.st  = ST_RX;
            ctl_d.ph  = PH_ID;
            ctl_d.cnt = '0;
            ctl_d.oe  = 1'b0;
        end else if (stop_det) begin
            ctl_d.st  = ST_IDLE;
            ctl_d.cnt = '0;
            ctl_d.oe  = 1'b0;
        end else begin
            unique case (ctl_q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        ctl_d.sr  = rx_byte;
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                        if (ctl_q.cnt == BIT_LAST) begin
                            ctl_d.cnt = '0;
                            ctl_d.st  = ST_WAIT;
                            unique case (ctl_q.ph)
                                PH_ID: begin
                                    if (id_ok) begin
                                        ctl_d.st = ST_ACKPEND;
                                        ctl_d.ph = PH_ADDR;
                                        ctl_d.nx = rx_byte[0] ? NX_TX : NX_RX;
                                    end
                                end
                                PH_ADDR: begin
                                    if (addr_ok) begin
                                        ctl_d.st  = ST_ACKPEND;
                                        ctl_d.ph  = PH_DATA;
                                        ctl_d.nx  = NX_RX;
                                        ctl_d.ptr = rx_byte[PTR_W-1:0];
                                    end
                                end
                                PH_DATA: begin
                                    wr_en    = 1'b1;
                                    ctl_d.st = ST_ACKPEND;
                                    ctl_d.nx = NX_WAIT;
                                end
                                default: ctl_d.st = ST_WAIT;
                            endcase
                        end
                    end
                end
                ST_ACKPEND: begin
                    if (scl_fall) begin
                        ctl_d.oe = 1'b1;
                        ctl_d.st = ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        unique case (ctl_q.nx)
                            NX_TX: begin
                                ctl_d.sr  = rd_data;
                                ctl_d.oe  = ~rd_data[BYTE_W-1];
                                ctl_d.cnt = '0;
                                ctl_d.st  = ST_TX;
                            end
                            NX_RX: begin
                                ctl_d.oe  = 1'b0;
                                ctl_d.cnt = '0;
                                ctl_d.st  = ST_RX;
                            end
                            default: begin
                                ctl_d.oe = 1'b0;
                                ctl_d.st = ST_WAIT;
                            end
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (ctl_q.cnt == BIT_LAST) begin
                            ctl_d.oe  = 1'b0;
                            ctl_d.cnt = '0;
                            ctl_d.st  = ST_MACK;
                            ctl_d.ptr = (ctl_q.ptr == PTR_LAST) ? '0 : ctl_q.ptr + 1'b1;
                        end else begin
                            ctl_d.sr  = {ctl_q.sr[BYTE_W-2:0], 1'b0};
                            ctl_d.oe  = ~ctl_q.sr[BYTE_W-2];
                            ctl_d.cnt = ctl_q.cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) ctl_d.st = sda_i ? ST_WAIT : ST_TXLOAD;
                end
                ST_TXLOAD: begin
                    if (scl_fall) begin
                        ctl_d.sr  = rd_data;
                        ctl_d.oe  = ~rd_data[BYTE_W-1];
                        ctl_d.cnt = '0;
                        ctl_d.st  = ST_TX;
                    end
                end
                default: ctl_d = ctl_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, ph: PH_ID, nx: NX_WAIT, cnt: '0,
                       sr: '0, ptr: '0, oe: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_oe_o = ctl_q.oe;
endmodule

// File: rtl/i2c_quad_setting_chk.sv
module i2c_quad_setting_chk #(
    parameter int NUM_REGS = 4,
    parameter logic [7:0] RESET_VAL = 8'h80
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_i,
    input logic                  sda_oe_o,
    input logic [NUM_REGS*8-1:0] wiper_o
);
    localparam logic [NUM_REGS*8-1:0] ALL_RESET = {NUM_REGS{RESET_VAL}};

    logic [NUM_REGS*8-1:0] prev_w;
    logic [NUM_REGS-1:0]   reg_chg;
    logic                  scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_w <= ALL_RESET;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            prev_w <= wiper_o;
            scl_p  <= scl_i;
            sda_p  <= sda_i;
        end
    end

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_chg
        assign reg_chg[gi] = wiper_o[gi*8 +: 8] != prev_w[gi*8 +: 8];
    end

    assert_reset_vals_R1: assert property (@(posedge clk)
        !rst_n |=> (wiper_o == ALL_RESET) && !sda_oe_o);

    assert_one_reg_per_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_chg));

    assert_write_on_scl_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_chg != '0) |-> (scl_p && !$past(scl_p)));

    assert_release_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && scl_p && sda_i && !sda_p) |=> !sda_oe_o);

    assert_oe_change_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_i));

    assert_oe_rise_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> (!$past(scl_i) && $past(scl_i, 2)));
endmodule

bind i2c_quad_setting_ctrl i2c_quad_setting_chk #(
    .NUM_REGS  (NUM_REGS),
    .RESET_VAL (RESET_VAL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_oe_o (sda_oe_o),
    .wiper_o  (wiper_o)
);

// File: tb/i2c_quad_setting_ctrl_test.sv
module i2c_quad_setting_ctrl_test;
    localparam int Q = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  strap;
    logic        sda_oe;
    logic [31:0] wiper;
    logic        bus_sda;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    int drive_cnt = 0;
    int viol = 0;

    logic [7:0] exp_r [4];
    logic [7:0] rd_buf [8];
    logic [2:0] rd_acks;

    assign bus_sda = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_quad_setting_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (bus_sda),
        .strap_i  (strap),
        .sda_oe_o (sda_oe),
        .wiper_o  (wiper)
    );

    logic scl_s = 1'b1;
    logic oe_s  = 1'b0;
    always @(negedge clk) begin
        #1;
        if (sda_oe) drive_cnt++;
        if ((sda_oe != oe_s) && scl && scl_s) viol++;
        scl_s = scl;
        oe_s  = sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_flat();
        return {exp_r[3], exp_r[2], exp_r[1], exp_r[0]};
    endfunction

    function automatic logic [7:0] id_byte(input logic [1:0] s, input logic rd);
        return {5'b01010, s, rd};
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic [31:0] snap);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl = 1'b1;   tick(2*Q);
            scl = 1'b0;   tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        ack  = ~bus_sda;
        snap = wiper;
        tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b[i] = bus_sda;
            tick(Q);
            scl = 1'b0;
        end
        tick(1);
        sda_m = ~mack; tick(Q);
        scl = 1'b1;    tick(2*Q);
        scl = 1'b0;    tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic raw_bytes(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                             output logic [2:0] acks);
        logic [31:0] s;
        sda_m = 1'b1; scl = 1'b0; tick(Q);
        send_byte(b0, acks[0], s);
        send_byte(b1, acks[1], s);
        send_byte(b2, acks[2], s);
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
    endtask

    task automatic wr_txn(input logic [7:0] id, input logic [7:0] addr, input logic [7:0] data,
                          output logic [2:0] acks, output logic [31:0] snap);
        logic [31:0] s;
        bus_start();
        send_byte(id, acks[0], s);
        send_byte(addr, acks[1], s);
        send_byte(data, acks[2], snap);
        bus_stop();
    endtask

    task automatic rd_txn(input logic [7:0] addr, input int n, input bit do_stop);
        logic [31:0] s;
        bus_start();
        send_byte(id_byte(strap, 1'b0), rd_acks[0], s);
        send_byte(addr, rd_acks[1], s);
        bus_start();
        send_byte(id_byte(strap, 1'b1), rd_acks[2], s);
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, rd_buf[k]);
        if (do_stop) bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [2:0]  acks;
        logic [31:0] snap;
        int          d0;
        logic        a;
        logic [7:0]  b;
        void'($urandom(32'd20240611));
        strap = 2'($urandom % 4);
        for (int i = 0; i < 4; i++) exp_r[i] = 8'h80;
        tick(3);
        chk("R1 reset values held", {wiper[31:1], sda_oe}, {32'h80808080 >> 1, 1'b0});
        rst_n = 1'b1;
        tick(4);
        chk("R1 reset values after release", wiper, 32'h80808080);
        chk("R1 sda released", {31'd0, sda_oe}, 32'd0);

        // R8: traffic with no START
        d0 = drive_cnt;
        raw_bytes(id_byte(strap, 1'b0), 8'h01, 8'h33, acks);
        chk("R8 no ack before start", {29'd0, acks}, 32'd0);
        chk("R8 no drive before start", drive_cnt - d0, 0);
        chk("R8 registers untouched", wiper, model_flat());

        // R4 directed write to register 2
        wr_txn(id_byte(strap, 1'b0), 8'h02, 8'h5A, acks, snap);
        exp_r[2] = 8'h5A;
        chk("R4 three acks on write", {29'd0, acks}, 32'd7);
        chk("R4 value visible in data ack clock", snap, model_flat());
        chk("R4 only target register changed", wiper, model_flat());

        // R9: bytes after STOP without START
        d0 = drive_cnt;
        raw_bytes(id_byte(strap, 1'b0), 8'h00, 8'h11, acks);
        chk("R9 no ack after stop", {29'd0, acks}, 32'd0);
        chk("R9 no drive after stop", drive_cnt - d0, 0);
        chk("R9 registers untouched", wiper, model_flat());

        // R2: wrong prefix and wrong strap
        wr_txn({5'b01011, strap, 1'b0}, 8'h01, 8'hC3, acks, snap);
        chk("R2 bad prefix not acked", {29'd0, acks}, 32'd0);
        wr_txn({5'b01010, ~strap, 1'b0}, 8'h01, 8'hC3, acks, snap);
        chk("R2 bad strap not acked", {29'd0, acks}, 32'd0);
        chk("R2 registers untouched", wiper, model_flat());

        // R3: out-of-range address
        wr_txn(id_byte(strap, 1'b0), 8'h04, 8'h77, acks, snap);
        chk("R3 address 04h not acked", {29'd0, acks}, 32'd1);
        chk("R3 data after bad address ignored", wiper, model_flat());

        // R11: surplus data byte
        bus_start();
        send_byte(id_byte(strap, 1'b0), acks[0], snap);
        send_byte(8'h00, acks[1], snap);
        send_byte(8'hE1, acks[2], snap);
        exp_r[0] = 8'hE1;
        send_byte(8'h1E, a, snap);
        bus_stop();
        chk("R11 write acks", {29'd0, acks}, 32'd7);
        chk("R11 surplus byte not acked", {31'd0, a}, 32'd0);
        chk("R11 surplus byte ignored", wiper, model_flat());

        // R5 R6: read from register 3 wraps to 0
        wr_txn(id_byte(strap, 1'b0), 8'h01, 8'h96, acks, snap); exp_r[1] = 8'h96;
        wr_txn(id_byte(strap, 1'b0), 8'h03, 8'h3C, acks, snap); exp_r[3] = 8'h3C;
        rd_txn(8'h03, 6, 1'b0);
        chk("R5 read phase acks", {29'd0, rd_acks}, 32'd7);
        for (int k = 0; k < 6; k++)
            chk($sformatf("R6 wrap byte %0d", k), {24'd0, rd_buf[k]}, {24'd0, exp_r[(3 + k) % 4]});

        // R7: after host NACK, clocking another byte gets no drive
        d0 = drive_cnt;
        raw_bytes(8'hFF, 8'hFF, 8'hFF, acks);
        chk("R7 silent after host nack", drive_cnt - d0, 0);
        bus_stop();

        // R3: rejected address keeps pointer (read of 1 byte from 2 leaves pointer at 3)
        rd_txn(8'h02, 1, 1'b1);
        chk("R5 single byte read", {24'd0, rd_buf[0]}, {24'd0, exp_r[2]});
        bus_start();
        send_byte(id_byte(strap, 1'b0), acks[0], snap);
        send_byte(8'h09, acks[1], snap);
        bus_start();
        send_byte(id_byte(strap, 1'b1), acks[2], snap);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R3 bad address acks", {29'd0, acks}, 32'd5);
        chk("R3 pointer unchanged by bad address", {24'd0, b}, {24'd0, exp_r[3]});

        // random mix
        for (int it = 0; it < 30; it++) begin
            int op;
            logic [7:0] ad, dt;
            op = int'($urandom % 3);
            dt = 8'($urandom);
            if (op == 0) begin
                ad = 8'($urandom % 4);
                wr_txn(id_byte(strap, 1'b0), ad, dt, acks, snap);
                exp_r[ad[1:0]] = dt;
                chk("R4 random write acks", {29'd0, acks}, 32'd7);
                chk("R4 random write value", wiper, model_flat());
            end else if (op == 1) begin
                int n;
                ad = 8'($urandom % 4);
                n  = 1 + int'($urandom % 6);
                rd_txn(ad, n, 1'b1);
                for (int k = 0; k < n; k++)
                    chk("R6 random read byte", {24'd0, rd_buf[k]}, {24'd0, exp_r[(int'(ad) + k) % 4]});
            end else begin
                ad = 8'(4 + ($urandom % 252));
                wr_txn(id_byte(strap, 1'b0), ad, dt, acks, snap);
                chk("R3 random bad address acks", {29'd0, acks}, 32'd1);
                chk("R3 random bad address no write", wiper, model_flat());
            end
        end

        chk("R10 enable changed while SCL high", viol, 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule